// File: doc/BRIEF.md
# Isochronous Overrun and Underrun Detector

This block sits beside the endpoint FIFOs of a USB device controller and watches the token stream. On every accepted token it checks the addressed endpoint. If that endpoint is one of the numbered data endpoints (1 up to `NUM_EP`) and is set to isochronous mode, the block tests for two faults. An OUT token that finds the endpoint's two-packet OUT FIFO already full is an overrun. An IN token that finds the endpoint's IN FIFO empty is an underrun. Endpoint 0 and non-isochronous endpoints are never checked.

Each fault produces a one-cycle pulse on a per-endpoint overrun or underrun output. Either fault also sets one shared interrupt flag. The flag holds the interrupt request high until software clears it with a write-one strobe. If a new fault arrives in the same cycle as the clear, the fault wins. The FIFOs and the handshake replies are outside this block. It only reads their occupancy.

Top module: `iso_xrun_detect`

## Requirements
- R1: A token addressed to an endpoint whose isochronous enable bit is 0 produces no pulse and leaves the flag unchanged. Bit n-1 of `iso_en` belongs to endpoint n.
- R2: A token for endpoint 0, or for any endpoint number above `NUM_EP`, produces no pulse and leaves the flag unchanged.
- R3: An OUT token (`tok_is_in` = 0) for an isochronous endpoint n whose packet count (field n-1 of `out_pkt_cnt`, `CNT_W` bits wide) is at least `OUT_DEPTH` (default 2) drives bit n-1 of `ovr_pulse` high in the cycle after the token. A count below `OUT_DEPTH` gives no pulse.
- R4: An IN token (`tok_is_in` = 1) for an isochronous endpoint n whose `in_has_data` bit n-1 is 0 drives bit n-1 of `udr_pulse` high in the cycle after the token. If the bit is 1 there is no pulse.
- R5: Any overrun or underrun sets `xrun_flag` at the same clock edge that raises its pulse. The flag stays 1 until it is cleared.
- R6: With `irq_clr` high and no fault in that cycle, `xrun_flag` is 0 after the next edge.
- R7: When a fault and `irq_clr` occur in the same cycle, `xrun_flag` stays 1.
- R8: While `rst_n` is low, all pulses and `xrun_flag` are 0.
- R9: A pulse lasts one cycle unless another faulting token follows. Across both pulse vectors, at most one bit is high in any cycle. No token means no pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | A token is present this cycle |
| tok_is_in | input | 1 | Token kind: 1 = IN, 0 = OUT |
| tok_ep | input | EP_W | Endpoint number addressed by the token |
| iso_en | input | NUM_EP | Isochronous mode per endpoint; bit n-1 is endpoint n |
| out_pkt_cnt | input | NUM_EP*CNT_W | Packets held in each OUT FIFO; field n-1 is endpoint n |
| in_has_data | input | NUM_EP | IN FIFO of endpoint n holds data (bit n-1) |
| irq_clr | input | 1 | Write-one clear of the shared flag |
| ovr_pulse | output | NUM_EP | One-cycle overrun pulse per endpoint |
| udr_pulse | output | NUM_EP | One-cycle underrun pulse per endpoint |
| xrun_flag | output | 1 | Sticky overrun/underrun interrupt request |

## Verification
The bench first drives directed tokens. OUT tokens are sent with packet counts of 1, 2 and 3, which separates the fill threshold from a plain equality test. IN tokens are sent with the data bit set and cleared, which checks the polarity of the empty test. Tokens for endpoint 0, for out-of-range endpoint numbers and for endpoints with isochronous mode off confirm that only qualified endpoints are tested. Clear strobes are given both alone and together with a fault, which shows whether the clear and the set are ordered correctly. Back-to-back faulting tokens to different endpoints test that pulses are routed to the right endpoint and last one cycle. A long random phase then mixes all of these cases under the per-cycle reference model.

// File: rtl/xrun_pkg.sv
package xrun_pkg;

   typedef enum logic {
      TOK_OUT = 1'b0,
      TOK_IN  = 1'b1
   } tok_kind_e;

   // true when a packet count has reached the stated fill limit
   function automatic logic fill_reached(input int unsigned cnt, input int unsigned lim);
      return cnt >= lim;
   endfunction

endpackage

// File: rtl/xrun_tok_decode.sv
module xrun_tok_decode
   import xrun_pkg::*;
#(
   parameter int NUM_EP = 4,
   parameter int EP_W   = 4
) (
   input  logic              tok_valid,
   input  logic              tok_is_in,
   input  logic [EP_W-1:0]   tok_ep,
   input  logic [NUM_EP-1:0] iso_en,
   output logic [NUM_EP-1:0] out_hit,
   output logic [NUM_EP-1:0] in_hit
);

   tok_kind_e kind;
   assign kind = tok_kind_e'(tok_is_in);

   for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
      localparam logic [EP_W-1:0] EP_NUM = EP_W'(i + 1);
      logic sel;
      assign sel        = tok_valid && (tok_ep == EP_NUM) && iso_en[i];
      assign out_hit[i] = sel && (kind == TOK_OUT);
      assign in_hit[i]  = sel && (kind == TOK_IN);
   end

endmodule

// File: rtl/xrun_ep_cond.sv
module xrun_ep_cond
   import xrun_pkg::*;
#(
   parameter int CNT_W     = 2,
   parameter int OUT_DEPTH = 2
) (
   input  logic             out_hit,
   input  logic             in_hit,
   input  logic [CNT_W-1:0] out_cnt,
   input  logic             in_has_data,
   output logic             ovr_ev,
   output logic             udr_ev
);

   logic full;
   assign full   = fill_reached(int'(out_cnt), OUT_DEPTH);
   assign ovr_ev = out_hit && full;
   assign udr_ev = in_hit && !in_has_data;

endmodule

// File: rtl/xrun_pulse_stage.sv
module xrun_pulse_stage #(
   parameter int NUM_EP    = 4,
   parameter bit PULSE_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EP-1:0] ovr_ev,
   input  logic [NUM_EP-1:0] udr_ev,
   output logic [NUM_EP-1:0] ovr_pulse,
   output logic [NUM_EP-1:0] udr_pulse
);

   if (PULSE_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ovr_pulse <= '0;
            udr_pulse <= '0;
         end else begin
            ovr_pulse <= ovr_ev;
            udr_pulse <= udr_ev;
         end
      end
   end else begin : g_comb
      assign ovr_pulse = ovr_ev;
      assign udr_pulse = udr_ev;
   end

endmodule

// File: rtl/xrun_sticky_flag.sv
module xrun_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr_req,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set_ev)  flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
   end

endmodule

// File: rtl/iso_xrun_detect.sv
module iso_xrun_detect #(
   parameter int NUM_EP    = 4,
   parameter int EP_W      = 4,
   parameter int CNT_W     = 2,
   parameter int OUT_DEPTH = 2,
   parameter bit PULSE_REG = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tok_valid,
   input  logic                    tok_is_in,
   input  logic [EP_W-1:0]         tok_ep,
   input  logic [NUM_EP-1:0]       iso_en,
   input  logic [NUM_EP*CNT_W-1:0] out_pkt_cnt,
   input  logic [NUM_EP-1:0]       in_has_data,
   input  logic                    irq_clr,
   output logic [NUM_EP-1:0]       ovr_pulse,
   output logic [NUM_EP-1:0]       udr_pulse,
   output logic                    xrun_flag
);

   localparam int MAX_EP_NUM = (1 << EP_W) - 1;
   localparam int MIN_CNT_W  = $clog2(OUT_DEPTH + 1);

   initial begin
      if (NUM_EP < 1 || NUM_EP > MAX_EP_NUM)
         $fatal(1, "NUM_EP must be 1..%0d", MAX_EP_NUM);
      if (OUT_DEPTH < 1)
         $fatal(1, "OUT_DEPTH must be at least 1");
      if (CNT_W < MIN_CNT_W)
         $fatal(1, "CNT_W must be at least %0d", MIN_CNT_W);
   end

   logic [NUM_EP-1:0] out_hit, in_hit;
   logic [NUM_EP-1:0] ovr_ev, udr_ev;
   logic              any_ev;

   xrun_tok_decode #(.NUM_EP(NUM_EP), .EP_W(EP_W)) dec_i (
      .tok_valid (tok_valid),
      .tok_is_in (tok_is_in),
      .tok_ep    (tok_ep),
      .iso_en    (iso_en),
      .out_hit   (out_hit),
      .in_hit    (in_hit)
   );

   for (genvar i = 0; i < NUM_EP; i++) begin : g_cond
      xrun_ep_cond #(.CNT_W(CNT_W), .OUT_DEPTH(OUT_DEPTH)) cond_i (
         .out_hit     (out_hit[i]),
         .in_hit      (in_hit[i]),
         .out_cnt     (out_pkt_cnt[i*CNT_W +: CNT_W]),
         .in_has_data (in_has_data[i]),
         .ovr_ev      (ovr_ev[i]),
         .udr_ev      (udr_ev[i])
      );
   end

   assign any_ev = (|ovr_ev) || (|udr_ev);

   xrun_pulse_stage #(.NUM_EP(NUM_EP), .PULSE_REG(PULSE_REG)) pls_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ovr_ev    (ovr_ev),
      .udr_ev    (udr_ev),
      .ovr_pulse (ovr_pulse),
      .udr_pulse (udr_pulse)
   );

   xrun_sticky_flag flg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_ev  (any_ev),
      .clr_req (irq_clr),
      .flag    (xrun_flag)
   );

endmodule

// File: rtl/iso_xrun_chk.sv
module iso_xrun_chk #(
   parameter int NUM_EP    = 4,
   parameter int EP_W      = 4,
   parameter int CNT_W     = 2,
   parameter int OUT_DEPTH = 2,
   parameter bit PULSE_REG = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    tok_valid,
   input logic                    tok_is_in,
   input logic [EP_W-1:0]         tok_ep,
   input logic [NUM_EP-1:0]       iso_en,
   input logic [NUM_EP*CNT_W-1:0] out_pkt_cnt,
   input logic [NUM_EP-1:0]       in_has_data,
   input logic                    irq_clr,
   input logic [NUM_EP-1:0]       ovr_pulse,
   input logic [NUM_EP-1:0]       udr_pulse,
   input logic                    xrun_flag
);

   logic             sel_iso;
   logic [CNT_W-1:0] sel_cnt;

   always_comb begin
      sel_iso = 1'b0;
      sel_cnt = '0;
      for (int i = 0; i < NUM_EP; i++) begin
         if (tok_ep == EP_W'(i + 1)) begin
            sel_iso = iso_en[i];
            sel_cnt = out_pkt_cnt[i*CNT_W +: CNT_W];
         end
      end
   end

   AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ovr_pulse, udr_pulse})); // R9

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      xrun_flag && !irq_clr |=> xrun_flag); // R5

   AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr && !tok_valid |=> !xrun_flag); // R6

   if (PULSE_REG) begin : g_reg
      AST_NONISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         tok_valid && !sel_iso |=> (ovr_pulse == '0) && (udr_pulse == '0)); // R1

      AST_EP0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         tok_valid && (tok_ep == '0) |=> (ovr_pulse == '0) && (udr_pulse == '0)); // R2

      AST_OVR_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
         tok_valid && !tok_is_in && sel_iso && (int'(sel_cnt) >= OUT_DEPTH)
         |=> (|ovr_pulse)); // R3

      AST_IN_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
         tok_valid && tok_is_in |=> (ovr_pulse == '0)); // R3

      AST_OUT_NO_UDR: assert property (@(posedge clk) disable iff (!rst_n)
         tok_valid && !tok_is_in |=> (udr_pulse == '0)); // R4

      AST_PULSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (|ovr_pulse) || (|udr_pulse) |-> xrun_flag); // R5

      AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !tok_valid |=> (ovr_pulse == '0) && (udr_pulse == '0)); // R9
   end else begin : g_comb
      AST_NONISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         tok_valid && !sel_iso |-> (ovr_pulse == '0) && (udr_pulse == '0)); // R1

      AST_PULSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (|ovr_pulse) || (|udr_pulse) |=> xrun_flag); // R5
   end

endmodule

bind iso_xrun_detect iso_xrun_chk #(
   .NUM_EP(NUM_EP), .EP_W(EP_W), .CNT_W(CNT_W),
   .OUT_DEPTH(OUT_DEPTH), .PULSE_REG(PULSE_REG)
) chk_i (.*);

// File: tb/iso_xrun_detect_tb_top.sv
`timescale 1ns/1ps
module iso_xrun_detect_tb_top;

   localparam int NUM_EP = 4;
   localparam int EP_W   = 4;
   localparam int CNT_W  = 2;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    tok_valid = 1'b0;
   logic                    tok_is_in = 1'b0;
   logic [EP_W-1:0]         tok_ep = '0;
   logic [NUM_EP-1:0]       iso_en = '0;
   logic [NUM_EP*CNT_W-1:0] out_pkt_cnt = '0;
   logic [NUM_EP-1:0]       in_has_data = '0;
   logic                    irq_clr = 1'b0;
   logic [NUM_EP-1:0]       ovr_pulse, udr_pulse;
   logic                    xrun_flag;

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_req = "R8";

   always #5 clk = ~clk;

   iso_xrun_detect dut_i (.*);

   // reference model
   logic [NUM_EP-1:0] exp_ovr, exp_udr;
   logic              exp_flag;
   string             exp_tag;

   always @(posedge clk or negedge rst_n) begin
      logic [NUM_EP-1:0] ov, ud;
      int e;
      if (!rst_n) begin
         exp_ovr  <= '0;
         exp_udr  <= '0;
         exp_flag <= 1'b0;
         exp_tag  <= "R8";
      end else begin
         ov = '0;
         ud = '0;
         e  = int'(tok_ep);
         if (tok_valid && e >= 1 && e <= NUM_EP && iso_en[e-1]) begin
            if (tok_is_in) begin
               if (!in_has_data[e-1]) ud[e-1] = 1'b1;
            end else if (int'(out_pkt_cnt[(e-1)*CNT_W +: CNT_W]) >= 2) begin
               ov[e-1] = 1'b1;
            end
         end
         exp_ovr <= ov;
         exp_udr <= ud;
         if (ov != 0 || ud != 0) exp_flag <= 1'b1;
         else if (irq_clr)       exp_flag <= 1'b0;
         exp_tag <= cur_req;
      end
   end

   always @(negedge clk) begin
      n_tests++;
      if (ovr_pulse !== exp_ovr) begin
         n_fail++;
         $display("FAIL %s ovr_pulse got %b expected %b at %0t", exp_tag, ovr_pulse, exp_ovr, $time);
      end
      n_tests++;
      if (udr_pulse !== exp_udr) begin
         n_fail++;
         $display("FAIL %s udr_pulse got %b expected %b at %0t", exp_tag, udr_pulse, exp_udr, $time);
      end
      n_tests++;
      if (xrun_flag !== exp_flag) begin
         n_fail++;
         $display("FAIL %s xrun_flag got %b expected %b at %0t", exp_tag, xrun_flag, exp_flag, $time);
      end
   end

   task automatic tok(input int ep, input bit is_in, input bit clr, input string req);
      @(negedge clk);
      cur_req   = req;
      tok_valid = 1'b1;
      tok_ep    = EP_W'(ep);
      tok_is_in = is_in;
      irq_clr   = clr;
   endtask

   task automatic idle(input int n, input bit clr, input string req);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         cur_req   = req;
         tok_valid = 1'b0;
         irq_clr   = clr;
      end
   endtask

   task automatic set_cnt(input int ep, input int c);
      out_pkt_cnt[(ep-1)*CNT_W +: CNT_W] = CNT_W'(c);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R8: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      iso_en = '1;
      in_has_data = '1;
      idle(2, 1'b0, "R8");

      // R3: OUT FIFO at 2, 1 and 3 packets
      set_cnt(2, 2); set_cnt(3, 1); set_cnt(4, 3); set_cnt(1, 0);
      tok(2, 1'b0, 1'b0, "R3");
      idle(2, 1'b0, "R3");
      tok(3, 1'b0, 1'b0, "R3");
      idle(1, 1'b0, "R3");
      tok(4, 1'b0, 1'b0, "R3");
      idle(1, 1'b0, "R3");
      // R5: flag holds over idle cycles
      idle(6, 1'b0, "R5");
      // R6: clear with no event
      idle(1, 1'b1, "R6");
      idle(2, 1'b0, "R6");

      // R4: IN FIFO empty vs holding data
      in_has_data = 4'b1110;
      tok(1, 1'b1, 1'b0, "R4");
      idle(1, 1'b0, "R4");
      tok(2, 1'b1, 1'b0, "R4");
      idle(1, 1'b1, "R6");
      idle(1, 1'b0, "R6");

      // R1: non-isochronous endpoints stay quiet
      iso_en = 4'b1010;
      in_has_data = '0;
      set_cnt(1, 3); set_cnt(3, 2);
      tok(1, 1'b0, 1'b0, "R1");
      tok(3, 1'b1, 1'b0, "R1");
      tok(1, 1'b1, 1'b0, "R1");
      idle(2, 1'b0, "R1");

      // R2: endpoint 0 and out-of-range numbers
      iso_en = '1;
      set_cnt(1, 3); set_cnt(2, 3); set_cnt(3, 3); set_cnt(4, 3);
      tok(0, 1'b0, 1'b0, "R2");
      tok(0, 1'b1, 1'b0, "R2");
      for (int ep = NUM_EP + 1; ep < 16; ep++) begin
         tok(ep, ep[0], 1'b0, "R2");
      end
      idle(2, 1'b0, "R2");

      // R7: event and clear together
      tok(3, 1'b1, 1'b1, "R7");
      idle(2, 1'b0, "R7");
      tok(4, 1'b0, 1'b1, "R7");
      idle(1, 1'b1, "R6");
      idle(1, 1'b0, "R6");

      // R9: back-to-back faults and pulse width
      tok(1, 1'b0, 1'b0, "R9");
      tok(2, 1'b1, 1'b0, "R9");
      tok(3, 1'b0, 1'b0, "R9");
      tok(4, 1'b1, 1'b0, "R9");
      idle(3, 1'b0, "R9");

      // R5: random mix under the model
      for (int k = 0; k < 2000; k++) begin
         @(negedge clk);
         cur_req     = "R5";
         tok_valid   = $urandom_range(0, 1) != 0;
         tok_is_in   = $urandom_range(0, 1) != 0;
         tok_ep      = EP_W'($urandom_range(0, 6));
         iso_en      = NUM_EP'($urandom);
         out_pkt_cnt = (NUM_EP*CNT_W)'($urandom);
         in_has_data = NUM_EP'($urandom);
         irq_clr     = $urandom_range(0, 7) == 0;
      end
      idle(3, 1'b0, "R5");

      finish_run();
   end

endmodule